// File: doc/BRIEF.md
# DMA Address Translation Window Unit

This block sits on the inbound DMA path of a bridge between a peripheral bus and a system interconnect. It turns a 32-bit bus-side DMA address into a 48-bit system physical address. The bus address space holds two windows.

- **Upper half (direct window).** Any address in the upper half of the bus space is remapped by removing a fixed base.
- **Translated window.** Addresses in the 1 GB region below the direct window are split into pages. Each page is looked up in an internal table of 64-bit translation entries. Each entry supplies a physical page, a 4-bit target port and five attribute flags. In the large configuration, one address bit in this window asks for byte swapping.

Software fills the table through a simple write port, using register offsets. A per-lookup control input selects a page size of 4 KB or 16 KB, and all entries share that size. A lookup is presented with `req_valid` and is always accepted. The result appears registered on the next cycle. It gives the physical address, the target port, the attributes, the swap flag and a fault flag. A faulting lookup carries no address.

Top module: `dma_xlate_unit`

## Requirements
- R1: After reset `rsp_valid` is 0, and every table entry is invalid, so any translated-window lookup faults until that entry is written.
- R2: A bus address from 0x8000_0000 to 0xFFFF_FFFF is a direct hit. It returns `rsp_pa` = address − 0x8000_0000, with port 0, attributes 0, swap 0 and no fault.
- R3: `rsp_valid` is 1 in exactly the cycle after a cycle with `req_valid` = 1, and is 0 otherwise.
- R4: A bus address from 0x4000_0000 to 0x7FFF_FFFF uses entry index = (address − 0x4000_0000) >> shift. Entry bit 0 = valid, bits 5:1 = attributes (`rsp_attr`), bits 11:8 = port, bits 47:12 = physical page. The result is `rsp_pa` = {entry[47:12], 12'b0} + (offset of the address within the page).
- R5: `page_large` = 0 selects 4 KB pages (shift 12). `page_large` = 1 selects 16 KB pages (shift 14).
- R6: A lookup that reaches an entry with bit 0 clear faults. Every faulting response drives `rsp_pa`, `rsp_port`, `rsp_attr` and `rsp_swap` to 0.
- R7: A translated-window lookup whose index is not below the entry count (128 small, 1024 large) faults.
- R8: A bus address below 0x4000_0000 faults.
- R9: In the large configuration, bus address bit 29 inside the translated window sets `rsp_swap`. The bit is cleared before the index is formed.
- R10: A write with `wr_en` = 1 at offset 0x1_0000 + 8 × i, for i below the entry count, stores `wr_data` in entry i. Misaligned offsets, and offsets below 0x1_0000 or past the last entry, change nothing.
- R11: A lookup in the same cycle as a write to the entry it reaches sees the entry's previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| page_large | input | 1 | Page size select: 0 = 4 KB, 1 = 16 KB |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Bus-side DMA address |
| wr_en | input | 1 | Table write strobe |
| wr_offset | input | REG_AW | Register offset of the write |
| wr_data | input | 64 | Entry word to store |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_fault | output | 1 | Lookup failed |
| rsp_pa | output | 48 | System physical address |
| rsp_port | output | 4 | Target port identifier |
| rsp_attr | output | 5 | Entry attribute flags (entry bits 5:1) |
| rsp_swap | output | 1 | Byte swap requested |

## Verification
The assertions assume that `req_addr` and `page_large` are stable around the clock edge that captures a request. They also assume that reset is released away from a clock edge. The bench drives every input on the falling edge and releases reset there, so this holds.

Table writes and lookups run freely in the same cycles. The direct-window and fault-shape properties hold whatever the table contents are. The bench's model applies each write only after it has formed the expected result for a lookup in the same cycle.

// File: rtl/dxu_pkg.sv
package dxu_pkg;
   localparam int BUS_AW      = 32;
   localparam int PA_W        = 48;
   localparam int ENT_W       = 64;
   localparam int PORT_W      = 4;
   localparam int ATTR_W      = 5;
   localparam int OFF_W       = 14;
   localparam int SMALL_SHIFT = 12;
   localparam int LARGE_SHIFT = 14;
   localparam int SMALL_COUNT = 128;
   localparam int LARGE_COUNT = 1024;
   localparam int SWAP_BIT    = 29;
   localparam int WIN_REL_W   = 30;

   // entry field positions (decoded by the result former)
   localparam int E_VALID   = 0;
   localparam int E_ATTR_LO = 1;
   localparam int E_PORT_LO = 8;
   localparam int E_PAGE_LO = 12;
   localparam int E_PAGE_HI = 47;

   localparam logic [BUS_AW-1:0] DIRECT_BASE = 32'h8000_0000;
   localparam logic [BUS_AW-1:0] XLATE_BASE  = 32'h4000_0000;
   localparam logic [31:0]       TABLE_BASE  = 32'h0001_0000;

   typedef enum logic [1:0] {
      WIN_NONE   = 2'd0,
      WIN_DIRECT = 2'd1,
      WIN_XLATE  = 2'd2
   } win_e;

   typedef struct packed {
      logic              fault;
      logic              swap;
      logic [PORT_W-1:0] port;
      logic [ATTR_W-1:0] attr;
      logic [PA_W-1:0]   pa;
   } xl_rsp_t;
endpackage

// File: rtl/dxu_window_decode.sv
module dxu_window_decode
   import dxu_pkg::*;
#(
   parameter bit SWAP_EN   = 1'b0,
   parameter int RAW_IDX_W = WIN_REL_W - SMALL_SHIFT
) (
   input  logic [BUS_AW-1:0]    bus_addr,
   input  logic                 page_large,
   output win_e                 win,
   output logic [RAW_IDX_W-1:0] raw_idx,
   output logic [OFF_W-1:0]     page_off,
   output logic                 swap_req
);
   logic [WIN_REL_W-1:0] rel;
   logic                 in_xlate;

   if (RAW_IDX_W != WIN_REL_W - SMALL_SHIFT) begin : g_chk_idx
      $error("RAW_IDX_W must cover the window at the small page size");
   end

   assign in_xlate = (bus_addr[BUS_AW-1:WIN_REL_W] == 2'b01);

   generate
      if (SWAP_EN) begin : g_swap
         assign swap_req = in_xlate & bus_addr[SWAP_BIT];
         assign rel      = {1'b0, bus_addr[SWAP_BIT-1:0]};
      end else begin : g_plain
         assign swap_req = 1'b0;
         assign rel      = bus_addr[WIN_REL_W-1:0];
      end
   endgenerate

   always_comb begin
      unique case (bus_addr[BUS_AW-1:WIN_REL_W])
         2'b10, 2'b11: win = WIN_DIRECT;
         2'b01:        win = WIN_XLATE;
         default:      win = WIN_NONE;
      endcase
   end

   always_comb begin
      if (page_large) begin
         raw_idx  = RAW_IDX_W'(rel >> LARGE_SHIFT);
         page_off = rel[LARGE_SHIFT-1:0];
      end else begin
         raw_idx  = RAW_IDX_W'(rel >> SMALL_SHIFT);
         page_off = {{(OFF_W-SMALL_SHIFT){1'b0}}, rel[SMALL_SHIFT-1:0]};
      end
   end
endmodule

// File: rtl/dxu_entry_table.sv
module dxu_entry_table
   import dxu_pkg::*;
#(
   parameter int NUM_ENTRIES = SMALL_COUNT,
   parameter int REG_AW      = 20,
   localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_offset,
   input  logic [ENT_W-1:0]  wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [ENT_W-1:0]  rd_entry
);
   localparam logic [REG_AW-1:0] BASE_OFF = REG_AW'(TABLE_BASE);
   localparam logic [REG_AW-1:0] END_OFF  = REG_AW'(TABLE_BASE + 8 * NUM_ENTRIES);

   if (longint'(TABLE_BASE) + 8 * NUM_ENTRIES > (longint'(1) << REG_AW)) begin : g_chk_aw
      $error("REG_AW too narrow for the entry table");
   end
   if ((1 << IDX_W) != NUM_ENTRIES) begin : g_chk_pow2
      $error("NUM_ENTRIES must be a power of two");
   end

   logic [ENT_W-1:0]  mem [NUM_ENTRIES];
   logic [REG_AW-1:0] rel_off;
   logic [IDX_W-1:0]  wr_idx;
   logic              wr_hit;

   assign rel_off = wr_offset - BASE_OFF;
   assign wr_idx  = rel_off[IDX_W+2:3];
   assign wr_hit  = wr_en && (wr_offset[2:0] == 3'b000)
                    && (wr_offset >= BASE_OFF) && (wr_offset < END_OFF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_ENTRIES; i++) mem[i] <= '0;
      end else if (wr_hit) begin
         mem[wr_idx] <= wr_data;
      end
   end

   assign rd_entry = mem[rd_idx];

   logic unused_off;
   assign unused_off = ^{rel_off[REG_AW-1:IDX_W+3], rel_off[2:0]};

   p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (mem[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/dxu_result_form.sv
module dxu_result_form
   import dxu_pkg::*;
#(
   parameter int NUM_ENTRIES = SMALL_COUNT,
   parameter int RAW_IDX_W   = WIN_REL_W - SMALL_SHIFT
) (
   input  win_e                 win,
   input  logic [BUS_AW-1:0]    bus_addr,
   input  logic [RAW_IDX_W-1:0] raw_idx,
   input  logic [OFF_W-1:0]     page_off,
   input  logic                 swap_req,
   input  logic [ENT_W-1:0]     entry,
   output xl_rsp_t              rsp
);
   logic in_range;
   logic [BUS_AW-1:0] direct_pa;
   logic [PA_W-1:0]   page_pa;

   assign in_range  = raw_idx < RAW_IDX_W'(NUM_ENTRIES);
   assign direct_pa = bus_addr - DIRECT_BASE;
   assign page_pa   = {entry[E_PAGE_HI:E_PAGE_LO], {E_PAGE_LO{1'b0}}};

   always_comb begin
      rsp = '0;
      unique case (win)
         WIN_DIRECT: begin
            rsp.pa = PA_W'(direct_pa);
         end
         WIN_XLATE: begin
            if (in_range && entry[E_VALID]) begin
               rsp.pa   = page_pa + PA_W'(page_off);
               rsp.port = entry[E_PORT_LO +: PORT_W];
               rsp.attr = entry[E_ATTR_LO +: ATTR_W];
               rsp.swap = swap_req;
            end else begin
               rsp.fault = 1'b1;
            end
         end
         default: rsp.fault = 1'b1;
      endcase
   end

   logic unused_ent;
   assign unused_ent = ^{entry[ENT_W-1:E_PAGE_HI+1], entry[E_PORT_LO-1:E_ATTR_LO+ATTR_W]};
endmodule

// File: rtl/dma_xlate_unit.sv
module dma_xlate_unit
   import dxu_pkg::*;
#(
   parameter bit LARGE_CFG = 1'b0,
   parameter int REG_AW    = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              page_large,
   input  logic              req_valid,
   input  logic [31:0]       req_addr,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_offset,
   input  logic [63:0]       wr_data,
   output logic              rsp_valid,
   output logic              rsp_fault,
   output logic [47:0]       rsp_pa,
   output logic [3:0]        rsp_port,
   output logic [4:0]        rsp_attr,
   output logic              rsp_swap
);
   localparam int NUM_ENTRIES = LARGE_CFG ? LARGE_COUNT : SMALL_COUNT;
   localparam int IDX_W       = $clog2(NUM_ENTRIES);
   localparam int RAW_IDX_W   = WIN_REL_W - SMALL_SHIFT;

   if (IDX_W > RAW_IDX_W) begin : g_chk_depth
      $error("table deeper than the translated window");
   end

   win_e                 win;
   logic [RAW_IDX_W-1:0] raw_idx;
   logic [OFF_W-1:0]     page_off;
   logic                 swap_req;
   logic [ENT_W-1:0]     entry;
   xl_rsp_t              rsp_d, rsp_q;

   dxu_window_decode #(.SWAP_EN(LARGE_CFG), .RAW_IDX_W(RAW_IDX_W)) u_decode (
      .bus_addr  (req_addr),
      .page_large(page_large),
      .win       (win),
      .raw_idx   (raw_idx),
      .page_off  (page_off),
      .swap_req  (swap_req)
   );

   dxu_entry_table #(.NUM_ENTRIES(NUM_ENTRIES), .REG_AW(REG_AW)) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_offset(wr_offset),
      .wr_data  (wr_data),
      .rd_idx   (raw_idx[IDX_W-1:0]),
      .rd_entry (entry)
   );

   dxu_result_form #(.NUM_ENTRIES(NUM_ENTRIES), .RAW_IDX_W(RAW_IDX_W)) u_form (
      .win     (win),
      .bus_addr(req_addr),
      .raw_idx (raw_idx),
      .page_off(page_off),
      .swap_req(swap_req),
      .entry   (entry),
      .rsp     (rsp_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_q     <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) rsp_q <= rsp_d;
      end
   end

   assign rsp_fault = rsp_q.fault;
   assign rsp_pa    = rsp_q.pa;
   assign rsp_port  = rsp_q.port;
   assign rsp_attr  = rsp_q.attr;
   assign rsp_swap  = rsp_q.swap;

   p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   p_direct_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr[31]) |=>
         (!rsp_fault && rsp_pa == {16'h0, $past(req_addr) - 32'h8000_0000}
          && rsp_port == 4'h0 && !rsp_swap));
   p_low_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr[31:30] == 2'b00) |=> rsp_fault);
   p_fault_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |->
         (rsp_pa == '0 && rsp_port == '0 && rsp_attr == '0 && !rsp_swap));
endmodule

// File: tb/dma_xlate_unit_tb.sv
`timescale 1ns/1ps
module dma_xlate_unit_tb;
   localparam int NENT = 1024;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        page_large = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        wr_en = 1'b0;
   logic [19:0] wr_offset = '0;
   logic [63:0] wr_data = '0;
   logic        rsp_valid, rsp_fault, rsp_swap;
   logic [47:0] rsp_pa;
   logic [3:0]  rsp_port;
   logic [4:0]  rsp_attr;

   always #10 clk = ~clk;

   dma_xlate_unit #(.LARGE_CFG(1'b1), .REG_AW(20)) u_dut (
      .clk(clk), .rst_n(rst_n), .page_large(page_large),
      .req_valid(req_valid), .req_addr(req_addr),
      .wr_en(wr_en), .wr_offset(wr_offset), .wr_data(wr_data),
      .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
      .rsp_port(rsp_port), .rsp_attr(rsp_attr), .rsp_swap(rsp_swap)
   );

   int errors = 0;
   int checks = 0;
   bit done = 0;

   logic [63:0] model_tbl [NENT];
   logic        exp_v = 0, exp_fault = 0, exp_swap = 0;
   logic [47:0] exp_pa = '0;
   logic [3:0]  exp_port = '0;
   logic [4:0]  exp_attr = '0;
   string       exp_tag = "R1";

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic model_lookup(input logic [31:0] a, input logic pl);
      logic [31:0] rel;
      int sh, idx;
      logic [63:0] e;
      exp_fault = 1; exp_swap = 0; exp_pa = '0; exp_port = '0; exp_attr = '0;
      if (a >= 32'h8000_0000) begin
         exp_fault = 0;
         exp_pa = {16'h0, a - 32'h8000_0000};
      end else if (a >= 32'h4000_0000) begin
         rel = (a & ~32'h2000_0000) - 32'h4000_0000;
         sh  = pl ? 14 : 12;
         idx = int'(rel >> sh);
         if (idx < NENT) begin
            e = model_tbl[idx];
            if (e[0]) begin
               exp_fault = 0;
               exp_swap  = a[29];
               exp_pa    = {e[47:12], 12'h000} + 48'(rel & ((32'd1 << sh) - 1));
               exp_port  = e[11:8];
               exp_attr  = e[5:1];
            end
         end
      end
   endtask

   // one cycle: called at a falling edge
   task automatic cyc(input logic rv, input logic [31:0] ra, input logic pl,
                      input logic we, input logic [19:0] wo, input logic [63:0] wd,
                      input string tag);
      chk(rsp_valid == exp_v, "R3", "rsp_valid", 64'(rsp_valid), 64'(exp_v));
      if (exp_v) begin
         chk(rsp_fault == exp_fault && rsp_pa == exp_pa && rsp_port == exp_port
             && rsp_attr == exp_attr && rsp_swap == exp_swap, exp_tag,
             "{fault,swap,port,attr,pa}",
             {5'h0, rsp_fault, rsp_swap, rsp_port, rsp_attr, rsp_pa},
             {5'h0, exp_fault, exp_swap, exp_port, exp_attr, exp_pa});
      end
      req_valid = rv; req_addr = ra; page_large = pl;
      wr_en = we; wr_offset = wo; wr_data = wd;
      exp_v = rv; exp_tag = tag;
      if (rv) model_lookup(ra, pl);
      if (we && wo[2:0] == 3'b000 && wo >= 20'h10000 && ((wo - 20'h10000) >> 3) < NENT)
         model_tbl[(wo - 20'h10000) >> 3] = wd;
      @(negedge clk);
   endtask

   task automatic look(input logic [31:0] a, input logic pl, input string tag);
      cyc(1'b1, a, pl, 1'b0, '0, '0, tag);
   endtask

   task automatic put(input int idx, input logic [63:0] d);
      cyc(1'b0, '0, 1'b0, 1'b1, 20'(32'h10000 + 8 * idx), d, "R10");
   endtask

   initial begin
      for (int i = 0; i < NENT; i++) model_tbl[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state, all entries invalid
      cyc(1'b0, '0, 1'b0, 1'b0, '0, '0, "R1");
      look(32'h4000_0000, 1'b0, "R1");
      look(32'h4000_5000, 1'b1, "R1");
      // R2: direct window
      look(32'h8000_0000, 1'b0, "R2");
      look(32'hFFFF_FFFF, 1'b0, "R2");
      look(32'h8123_4567, 1'b1, "R2");
      // R8: below both windows
      look(32'h0000_0000, 1'b0, "R8");
      look(32'h3FFF_FFFF, 1'b0, "R8");
      // R10: fill entries
      put(0,    64'h0000_0ABC_DEF0_1000 | 64'h500 | 64'h2B);
      put(1,    64'h0000_0001_0000_0000 | 64'h300 | 64'h01);
      put(2,    64'h0000_0000_7777_7000 | 64'hA00 | 64'h3E);
      put(1023, 64'h0000_8000_0000_0000 | 64'hF00 | 64'h03);
      // R4: translated hits, small pages (R5 shift 12)
      look(32'h4000_0123, 1'b0, "R4");
      look(32'h4000_1FFF, 1'b0, "R4");
      look(32'h403F_F800, 1'b0, "R5");
      // R6: entry 2 valid bit clear
      look(32'h4000_2010, 1'b0, "R6");
      // R7: index out of range at each page size
      look(32'h4040_0000, 1'b0, "R7");
      look(32'h4100_0000, 1'b1, "R7");
      // R5: 16 KB pages
      look(32'h4000_3FFF, 1'b1, "R5");
      look(32'h4000_4000, 1'b1, "R5");
      look(32'h40FF_C004, 1'b1, "R5");
      // R9: swap bit cleared before indexing
      look(32'h6000_0010, 1'b0, "R9");
      look(32'h6000_4abc, 1'b1, "R9");
      look(32'h603F_F000, 1'b0, "R9");
      // R11: write and lookup to the same entry in one cycle
      cyc(1'b1, 32'h4000_3008, 1'b0, 1'b1, 20'h10018, 64'h0000_0000_1234_5F01, "R11");
      look(32'h4000_3008, 1'b0, "R11");
      // R10: ignored writes (misaligned, below base, past last entry)
      cyc(1'b0, '0, 1'b0, 1'b1, 20'h10004, 64'h0000_0000_0000_0F01, "R10");
      cyc(1'b0, '0, 1'b0, 1'b1, 20'h08000, 64'h0000_0000_0000_0F01, "R10");
      cyc(1'b0, '0, 1'b0, 1'b1, 20'h12000, 64'h0000_0000_0000_0F01, "R10");
      look(32'h4000_0000, 1'b0, "R10");
      look(32'h4000_8000, 1'b0, "R10");
      // R10: invalidate entry 1 again
      put(1, 64'h0);
      look(32'h4000_1000, 1'b0, "R6");
      // R3: mixed traffic with bubbles and random writes
      for (int k = 0; k < 400; k++) begin
         logic [31:0] ra;
         int wi;
         ra = $urandom;
         if (k % 3 == 0) ra = {2'b01, 8'h00, 22'($urandom)};
         wi = $urandom_range(0, 15);
         cyc(1'($urandom_range(0, 3) != 0), ra, 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 4) == 0), 20'(32'h10000 + 8 * wi),
             {16'h0, 36'($urandom), 4'($urandom), 2'b00, 5'($urandom), 1'($urandom)},
             "R3");
      end
      cyc(1'b0, '0, 1'b0, 1'b0, '0, '0, "R3");
      cyc(1'b0, '0, 1'b0, 1'b0, '0, '0, "R3");
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++; checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule